// File: doc/BRIEF.md
# Octave Clock Divider with Gated Complementary Outputs

This block is the digital back end of a programmable clock source. A fast master clock enters, which stands in for an oscillator that already covers one octave. A 4-bit octave code selects one of sixteen power-of-two division ratios. Code 15 passes the master clock through unchanged. Each lower code halves the output frequency, so the ratio is 2^(15 − code). The divided clock drives a main output and an auxiliary output that is its inverse, shifted by half a period.

A 2-bit configuration code chooses between three states:
- both outputs running;
- one output running while the other is held low;
- a powered-down state that stops the divider and raises a flag.

An output-enable input forces both outputs low at once, without waiting for a clock edge. A new octave code is taken only at the end of a whole output period, which is the falling edge of the main clock. As a result, a ratio change never produces a shortened pulse.

Top module: `octaveClockOut`

## Requirements
- R1: For octave codes 0 to 14, the main output period is 2^(15 − code) master-clock cycles.
- R2: For octave codes 0 to 14, the main output is high for exactly half of each period and low for the other half.
- R3: With octave code 15, the main output equals the master clock and the auxiliary output equals its inverse.
- R4: When both outputs are enabled, the auxiliary output is always the inverse of the main output.
- R5: Configuration code 00 runs both outputs.
- R6: Configuration code 01 holds the auxiliary output low and keeps the main output toggling.
- R7: Configuration code 10 holds the main output low and keeps the auxiliary output toggling.
- R8: Configuration code 11 has these effects one cycle after the code is applied:
  - `pwrDown` goes high;
  - the divider stops;
  - both outputs stay low.
- R9: While `outEnable` is low, both outputs are low immediately, with no clock edge needed. Raising `outEnable` restores them.
- R10: After reset, the octave code in effect is 0, both outputs are enabled and `pwrDown` is low. The first period is 16384 cycles low, then 16384 cycles high.
- R11: A change of octave code takes effect only at the falling edge of the main output. The period in progress completes at the old ratio.
- R12: On leaving the powered-down state, the divider restarts from the start of a low phase at the octave code presented at that time. It then produces full-length high phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| octCode | input | 4 | Octave code; ratio is 2^(15 − octCode) |
| cfgCode | input | 2 | 00 both on, 01 main only, 10 auxiliary only, 11 powered down |
| outEnable | input | 1 | Asynchronous output enable, active high |
| clkMain | output | 1 | Main divided clock |
| clkAux | output | 1 | Inverted (180°) divided clock |
| pwrDown | output | 1 | High while in the powered-down state |

## Verification
A wrong half-period count or a wrong reload value changes the length of the main output's high and low runs. That shows up at the first falling edge after the fault. The scoreboard compares every measured run against 2^(14 − code).

If the active octave code is latched at the wrong moment, the period straddling the change comes out with a mixed length. That is caught within one old-ratio period.

A faulty decode of the configuration code shows one cycle after the code changes, as a gated output that keeps toggling or an enabled output that stays low. An enable path that waits for a clock shows as an output still high one nanosecond after `outEnable` falls.

// File: rtl/octdiv_pkg.sv
package octdiv_pkg;

  parameter int OCT_W = 4;
  localparam int MAX_SHIFT = (1 << OCT_W) - 1;
  localparam int CNT_W = MAX_SHIFT - 1;

  typedef enum logic [1:0] {
    CFG_BOTH      = 2'b00,
    CFG_MAIN_ONLY = 2'b01,
    CFG_AUX_ONLY  = 2'b10,
    CFG_SLEEP     = 2'b11
  } cfgMode_t;

  // Strobes from control to the divider datapath.
  typedef struct packed {
    logic             run;
    logic             bypass;
    logic [CNT_W-1:0] reloadVal;
  } divCtrl_t;

  // Half-period reload value: 2^(shift-1) - 1 with shift = MAX_SHIFT - oct.
  function automatic logic [CNT_W-1:0] halfSpan(input logic [OCT_W-1:0] oct);
    int shift;
    shift = MAX_SHIFT - int'(oct);
    if (shift <= 0) return '0;
    return CNT_W'((1 << (shift - 1)) - 1);
  endfunction

endpackage

// File: rtl/octCtrl.sv
module octCtrl
  import octdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OCT_W-1:0] octCode,
  input  logic [1:0]       cfgCode,
  input  logic             periodEnd,
  output divCtrl_t         ctrl,
  output logic             mainOn,
  output logic             auxOn,
  output logic             pwrDown
);

  logic [OCT_W-1:0] activeOct;
  logic             takeNew;

  assign takeNew = periodEnd || pwrDown;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeOct <= '0;
      mainOn    <= 1'b1;
      auxOn     <= 1'b1;
      pwrDown   <= 1'b0;
    end else begin
      if (takeNew) activeOct <= octCode;
      unique case (cfgMode_t'(cfgCode))
        CFG_BOTH:      begin mainOn <= 1'b1; auxOn <= 1'b1; pwrDown <= 1'b0; end
        CFG_MAIN_ONLY: begin mainOn <= 1'b1; auxOn <= 1'b0; pwrDown <= 1'b0; end
        CFG_AUX_ONLY:  begin mainOn <= 1'b0; auxOn <= 1'b1; pwrDown <= 1'b0; end
        CFG_SLEEP:     begin mainOn <= 1'b0; auxOn <= 1'b0; pwrDown <= 1'b1; end
      endcase
    end
  end

  always_comb begin
    ctrl.run       = !pwrDown;
    ctrl.bypass    = (int'(activeOct) == MAX_SHIFT);
    ctrl.reloadVal = takeNew ? halfSpan(octCode) : halfSpan(activeOct);
  end

  // R11
  oct_change_on_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && activeOct != $past(activeOct)) |-> $past(takeNew));

  // R8
  sleep_gates_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |-> (!mainOn && !auxOn && !ctrl.run));

endmodule

// File: rtl/octDiv.sv
module octDiv
  import octdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  divCtrl_t ctrl,
  output logic     divClk,
  output logic     periodEnd
);

  logic [CNT_W-1:0] halfCnt;
  logic             divQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= halfSpan('0);
      divQ    <= 1'b0;
    end else if (!ctrl.run || ctrl.bypass) begin
      halfCnt <= ctrl.reloadVal;
      divQ    <= 1'b0;
    end else if (halfCnt == '0) begin
      divQ    <= ~divQ;
      halfCnt <= ctrl.reloadVal;
    end else begin
      halfCnt <= halfCnt - 1'b1;
    end
  end

  assign periodEnd = ctrl.run && (ctrl.bypass || (halfCnt == '0 && divQ));
  assign divClk    = ctrl.bypass ? clk : divQ;

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.run && !ctrl.bypass && halfCnt != '0) |=> $stable(divQ));

  // R1
  countdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.run && !ctrl.bypass && halfCnt != '0) |=> (halfCnt == $past(halfCnt) - 1'b1));

  // R8
  stopped_divider_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.run |=> !divQ);

endmodule

// File: rtl/octaveClockOut.sv
module octaveClockOut
  import octdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OCT_W-1:0] octCode,
  input  logic [1:0]       cfgCode,
  input  logic             outEnable,
  output logic             clkMain,
  output logic             clkAux,
  output logic             pwrDown
);

  divCtrl_t ctrlBus;
  logic     periodEnd;
  logic     divClk;
  logic     mainOn;
  logic     auxOn;

  octCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .octCode  (octCode),
    .cfgCode  (cfgCode),
    .periodEnd(periodEnd),
    .ctrl     (ctrlBus),
    .mainOn   (mainOn),
    .auxOn    (auxOn),
    .pwrDown  (pwrDown)
  );

  octDiv uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrlBus),
    .divClk   (divClk),
    .periodEnd(periodEnd)
  );

  assign clkMain = outEnable & mainOn & divClk;
  assign clkAux  = outEnable & auxOn & ~divClk;

  // R9
  oe_forces_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outEnable |-> (!clkMain && !clkAux));

  // R4
  never_both_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(clkMain && clkAux));

  // R6
  aux_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cfgCode) == 2'b01) |-> !clkAux);

  // R7
  main_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cfgCode) == 2'b10) |-> !clkMain);

  // R8
  pd_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cfgCode) == 2'b11) |-> (pwrDown && !clkMain && !clkAux));

endmodule

// File: tb/tb_octaveClockOut.sv
module tb_octaveClockOut;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] octCode;
  logic [1:0] cfgCode;
  logic       outEnable;
  logic       clkMain;
  logic       clkAux;
  logic       pwrDown;

  octaveClockOut dut (
    .clk(clk), .rstN(rstN), .octCode(octCode), .cfgCode(cfgCode),
    .outEnable(outEnable), .clkMain(clkMain), .clkAux(clkAux), .pwrDown(pwrDown)
  );

  always #10 clk = ~clk;

  typedef struct {
    string req;
    int    hi;
    int    lo;
    bit    checkLo;
  } runItem_t;

  runItem_t sb[$];
  int nChecks = 0;
  int nFail = 0;
  int fallCount = 0;
  int runLen = 0;
  int loLen = 0;
  int hiLen = 0;
  logic prevLvl = 1'b0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures high/low run lengths of clkMain at falling master edges.
  always @(negedge clk) begin
    if (rstN !== 1'b1) begin
      prevLvl = 1'b0;
      runLen  = 0;
    end else begin
      if (clkMain == prevLvl) runLen++;
      else begin
        if (clkMain) loLen = runLen;
        else begin
          hiLen = runLen;
          fallCount++;
          if (sb.size() > 0) begin
            runItem_t it;
            it = sb.pop_front();
            check(hiLen == it.hi, {it.req, " high run"}, hiLen, it.hi);
            if (it.checkLo) check(loLen == it.lo, {it.req, " low run"}, loLen, it.lo);
          end
        end
        runLen = 1;
      end
      prevLvl = clkMain;
    end
  end

  task automatic waitFalls(input int n);
    int target;
    target = fallCount + n;
    wait (fallCount >= target);
  endtask

  task automatic waitEmpty();
    wait (sb.size() == 0);
  endtask

  task automatic pushRun(input string req, input int hi, input int lo, input bit chkLo);
    runItem_t it;
    it.req = req; it.hi = hi; it.lo = lo; it.checkLo = chkLo;
    sb.push_back(it);
  endtask

  // Driver: applies an octave code and queues the expected half period.
  task automatic runOct(input int oct, input string req);
    int ratio;
    ratio = 1 << (15 - oct);
    @(posedge clk); #3;
    octCode = 4'(oct);
    waitFalls(2);
    pushRun(req, ratio / 2, ratio / 2, 1'b1);
    waitEmpty();
  endtask

  task automatic sampleOutputs(input int n, output int mainHi, output int auxHi, output int mism);
    mainHi = 0; auxHi = 0; mism = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clkMain) mainHi++;
      if (clkAux) auxHi++;
      if (clkAux == clkMain) mism++;
    end
  endtask

  initial begin
    int mHi, aHi, mm;
    rstN = 1'b0; octCode = 4'd0; cfgCode = 2'b00; outEnable = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    check(pwrDown == 1'b0, "R10 pwrDown after reset", pwrDown, 0);
    check(clkMain == 1'b0, "R10 clkMain after reset", clkMain, 0);
    check(clkAux == 1'b1, "R10 clkAux after reset", clkAux, 1);
    @(posedge clk); #5;
    rstN = 1'b1;
    pushRun("R10 first period", 16384, 16384, 1'b1);
    #20 octCode = 4'd14;   // R11: waits for the period end
    waitEmpty();

    runOct(14, "R1 oct14");
    runOct(13, "R1 oct13");
    runOct(10, "R2 oct10");
    runOct(5,  "R1 oct5");

    // R11: change mid-period, current period completes at old ratio
    runOct(10, "R11 setup");
    waitFalls(1);
    repeat (5) @(posedge clk);
    #3 octCode = 4'd12;
    pushRun("R11 old period", 16, 16, 1'b1);
    pushRun("R11 new period", 4, 4, 1'b1);
    waitEmpty();

    // R4 / R5: both outputs running and complementary
    sampleOutputs(40, mHi, aHi, mm);
    check(mm == 0, "R4 aux inverse of main", mm, 0);
    check(mHi > 0 && aHi > 0, "R5 both toggle", mHi * aHi, 1);

    // R6
    @(posedge clk); #3 cfgCode = 2'b01;
    repeat (2) @(posedge clk);
    sampleOutputs(40, mHi, aHi, mm);
    check(aHi == 0, "R6 aux held low", aHi, 0);
    check(mHi > 0, "R6 main toggles", mHi, 20);

    // R7
    @(posedge clk); #3 cfgCode = 2'b10;
    repeat (2) @(posedge clk);
    sampleOutputs(40, mHi, aHi, mm);
    check(mHi == 0, "R7 main held low", mHi, 0);
    check(aHi > 0, "R7 aux toggles", aHi, 20);

    // R8
    @(posedge clk); #3 cfgCode = 2'b11;
    repeat (2) @(posedge clk);
    #3 check(pwrDown == 1'b1, "R8 pwrDown set", pwrDown, 1);
    octCode = 4'd13;
    sampleOutputs(40, mHi, aHi, mm);
    check(mHi == 0 && aHi == 0, "R8 outputs low", mHi + aHi, 0);

    // R12: wake with new code
    @(posedge clk); #3 cfgCode = 2'b00;
    pushRun("R12 wake high run", 2, 2, 1'b0);
    waitEmpty();
    check(pwrDown == 1'b0, "R12 pwrDown cleared", pwrDown, 0);
    pushRun("R12 full period", 2, 2, 1'b1);
    waitEmpty();

    // R3: passthrough
    @(posedge clk); #3 octCode = 4'd15;
    repeat (10) @(posedge clk);
    #4;
    check(clkMain == 1'b1, "R3 main follows clk high", clkMain, 1);
    check(clkAux == 1'b0, "R3 aux inverse high", clkAux, 0);
    @(negedge clk); #4;
    check(clkMain == 1'b0, "R3 main follows clk low", clkMain, 0);
    check(clkAux == 1'b1, "R3 aux inverse low", clkAux, 1);

    // R9: asynchronous enable
    @(posedge clk); #4;
    outEnable = 1'b0;
    #1;
    check(clkMain == 1'b0, "R9 main forced low", clkMain, 0);
    check(clkAux == 1'b0, "R9 aux forced low", clkAux, 0);
    sampleOutputs(10, mHi, aHi, mm);
    check(mHi == 0 && aHi == 0, "R9 stays low", mHi + aHi, 0);
    @(posedge clk); #4;
    outEnable = 1'b1;
    #1;
    check(clkMain == 1'b1, "R9 main restored", clkMain, 1);

    // R3: leaving passthrough gives clean periods
    runOct(14, "R3 exit passthrough");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule